// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block sits between a synchronous request source and an external asynchronous static RAM. It accepts a one-cycle write request carrying an address, a data word and a style bit. It then produces the chip-select and write-strobe waveforms, the held address and data, and a data-bus drive enable. All of them keep the minimum timings of the selected speed grade (25, 35 or 45 ns parts). Each nanosecond limit is converted to whole clock cycles from the clock-period parameter, rounding up, with a floor of one cycle.

Two write styles are offered. In the first, the write strobe ends the write while chip select stays low around it. In the second, the write strobe is lowered first, so that the memory never turns its outputs on, and the rising chip select ends the write. In both styles the address is changed only while both strobes are high. The data driver is turned on only after the memory has had time to release the bus. A busy flag, a one-cycle done pulse and a turnaround flag report progress.

Top module: `sramWriteSeq`

## Requirements
- R1: After reset, chipSelN and writeN are 1, and busy, done, dataOe and turnaround are 0.
- R2: A request (reqValid=1) seen at a clock edge while busy is 0 is accepted. busy is 1 from the next cycle on, and sramAddr/sramData show the requested address and data from that cycle on.
- R3: A request seen while busy is 1 is ignored. It produces no extra done pulse and no change of sramAddr, which keeps the accepted address after the write finishes.
- R4: With reqMode=0 (write strobe ends the write), the first busy cycle has chipSelN=0 and writeN=1. writeN is then low for S cycles, and chipSelN stays low for the whole busy period. No cycle has writeN low while chipSelN is high.
- R5: With reqMode=1 (chip select ends the write), the first busy cycle has writeN=0 and chipSelN=1. chipSelN is then low for S cycles, and writeN stays low for the whole busy period. No cycle has chipSelN low while writeN is high.
- R6: Each limit becomes a count of max(1, ceil(ns / CLK_NS)) cycles. S = max(pulse, turn + dataSetup, addrSetup - 1).
- R7: dataOe is 1 only while both strobes are low. It rises once turn cycles have passed since writeN fell, and falls in the cycle in which the ending strobe rises. It is high for S - turn cycles in mode 0 and for S - turn + 1 cycles in mode 1.
- R8: sramAddr does not change while busy is 1. Both strobes are 1 whenever busy is 0.
- R9: busy stays 1 for 1 + S + R cycles, with R = max(1, cycle - 1 - S).
- R10: done is 1 for exactly one cycle: the first cycle with busy back at 0. A new request may be accepted in that cycle.
- R11: turnaround is 1 while writeN is low and dataOe is not yet 1. That lasts turn cycles in both styles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle write request |
| reqAddr | input | ADDR_W | Write address |
| reqData | input | DATA_W | Write data |
| reqMode | input | 1 | 0: write strobe ends the write, 1: chip select ends it |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse after the cycle completes |
| turnaround | output | 1 | Memory may still drive the data bus |
| chipSelN | output | 1 | Active-low chip select to the memory |
| writeN | output | 1 | Active-low write strobe to the memory |
| sramAddr | output | ADDR_W | Held address to the memory |
| sramData | output | DATA_W | Held write data |
| dataOe | output | 1 | Enable for the data-bus driver |

## Verification
The bench builds the block with a 10 ns clock period and the 45 ns grade. With these values the output-release time takes two cycles and data setup takes two. The write pulse is therefore set by turnaround plus data setup (four cycles) rather than by the pulse minimum, and the recovery phase falls to its one-cycle floor. Both styles are run back to back, including a request in the done cycle, and an extra request is issued in the middle of a write. Exact strobe, enable and turnaround cycle counts are compared against values worked out from the ns limits.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER
  } wrState_t;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oe;
    logic turn;
    logic load;
  } strobe_t;

  // Limit selectors
  localparam int LIM_CYCLE = 0;
  localparam int LIM_PULSE = 1;
  localparam int LIM_DSET  = 2;
  localparam int LIM_ASET  = 3;
  localparam int LIM_TURN  = 4;

  function automatic int gradeNs(int grade, int which);
    int v;
    v = 0;
    case (grade)
      25: case (which)
            LIM_CYCLE: v = 25; LIM_PULSE: v = 20; LIM_DSET: v = 10;
            LIM_ASET:  v = 20; default:   v = 10;
          endcase
      35: case (which)
            LIM_CYCLE: v = 35; LIM_PULSE: v = 25; LIM_DSET: v = 12;
            LIM_ASET:  v = 25; default:   v = 13;
          endcase
      default: case (which)
            LIM_CYCLE: v = 45; LIM_PULSE: v = 30; LIM_DSET: v = 15;
            LIM_ASET:  v = 30; default:   v = 15;
          endcase
    endcase
    return v;
  endfunction

  function automatic int nsToCycles(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramWrCtrl.sv
module sramWrCtrl
  import sram_wr_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int SPEED_GRADE = 45
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqMode,
  output strobe_t strobes,
  output logic    busy,
  output logic    done
);

  localparam int PULSE_C = nsToCycles(gradeNs(SPEED_GRADE, LIM_PULSE), CLK_NS);
  localparam int DSET_C  = nsToCycles(gradeNs(SPEED_GRADE, LIM_DSET), CLK_NS);
  localparam int ASET_C  = nsToCycles(gradeNs(SPEED_GRADE, LIM_ASET), CLK_NS);
  localparam int TURN_C  = nsToCycles(gradeNs(SPEED_GRADE, LIM_TURN), CLK_NS);
  localparam int CYC_C   = nsToCycles(gradeNs(SPEED_GRADE, LIM_CYCLE), CLK_NS);
  localparam int STROBE_C = maxOf(maxOf(PULSE_C, TURN_C + DSET_C), maxOf(1, ASET_C - 1));
  localparam int REC_C    = maxOf(1, CYC_C - 1 - STROBE_C);
  localparam int CNT_W    = $clog2(maxOf(STROBE_C, REC_C) + 1);

  wrState_t   state;
  logic [CNT_W-1:0] cnt;
  logic       modeCe;
  logic       doneQ;
  logic [CNT_W:0]   cntAdj;
  logic       oeNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      modeCe <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: if (reqValid) begin
          state  <= ST_SETUP;
          modeCe <= reqMode;
          cnt    <= '0;
        end
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt   <= '0;
        end
        ST_STROBE: begin
          if (cnt == CNT_W'(STROBE_C - 1)) begin
            state <= ST_RECOVER;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CNT_W'(REC_C - 1)) begin
            state <= ST_IDLE;
            cnt   <= '0;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // Cycles since writeN fell: setup counts as one in chip-select style
  assign cntAdj = {1'b0, cnt} + {{CNT_W{1'b0}}, modeCe};
  assign oeNow  = (cntAdj >= (CNT_W + 1)'(TURN_C));

  always_comb begin
    strobes      = '0;
    strobes.ceN  = 1'b1;
    strobes.weN  = 1'b1;
    strobes.load = (state == ST_IDLE) && reqValid;
    case (state)
      ST_SETUP: begin
        strobes.ceN  = modeCe;
        strobes.weN  = !modeCe;
        strobes.turn = modeCe && (TURN_C > 0);
      end
      ST_STROBE: begin
        strobes.ceN  = 1'b0;
        strobes.weN  = 1'b0;
        strobes.oe   = oeNow;
        strobes.turn = !oeNow;
      end
      ST_RECOVER: begin
        strobes.ceN = modeCe;
        strobes.weN = !modeCe;
      end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = doneQ;

endmodule

// File: rtl/sramWrPath.sv
module sramWrPath
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              chipSelN,
  output logic              writeN,
  output logic              dataOe,
  output logic              turnaround,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.load) begin
      addrQ <= reqAddr;
      dataQ <= reqData;
    end
  end

  assign sramAddr   = addrQ;
  assign sramData   = dataQ;
  assign chipSelN   = strobes.ceN;
  assign writeN     = strobes.weN;
  assign dataOe     = strobes.oe;
  assign turnaround = strobes.turn;

endmodule

// File: rtl/sramWriteSeq.sv
module sramWriteSeq
  import sram_wr_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int SPEED_GRADE = 45,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqMode,
  output logic              busy,
  output logic              done,
  output logic              turnaround,
  output logic              chipSelN,
  output logic              writeN,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramData,
  output logic              dataOe
);

  strobe_t strobes;

  sramWrCtrl #(
    .CLK_NS(CLK_NS),
    .SPEED_GRADE(SPEED_GRADE)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .reqValid(reqValid),
    .reqMode(reqMode),
    .strobes(strobes),
    .busy(busy),
    .done(done)
  );

  sramWrPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uPath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .reqAddr(reqAddr),
    .reqData(reqData),
    .chipSelN(chipSelN),
    .writeN(writeN),
    .dataOe(dataOe),
    .turnaround(turnaround),
    .sramAddr(sramAddr),
    .sramData(sramData)
  );

endmodule

// File: rtl/sramWriteSeqChk.sv
module sramWriteSeqChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              chipSelN,
  input logic              writeN,
  input logic              dataOe,
  input logic [ADDR_W-1:0] sramAddr
);

  // R8: address frozen while both strobes stay low
  p_addr_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && !writeN && !$past(chipSelN) && !$past(writeN)) |-> (sramAddr == $past(sramAddr)));

  // R3: a busy cycle never lets the address move
  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (sramAddr == $past(sramAddr)));

  // R7: driver only on while both strobes low
  p_oe_inside_r7: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!chipSelN && !writeN));

  // R8: strobes idle high
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (chipSelN && writeN));

  // R10: done is a single cycle right after busy
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_after_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

endmodule

bind sramWriteSeq sramWriteSeqChk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk),
  .rstN(rstN),
  .busy(busy),
  .done(done),
  .chipSelN(chipSelN),
  .writeN(writeN),
  .dataOe(dataOe),
  .sramAddr(sramAddr)
);

// File: tb/sim_sramWriteSeq.sv
module sim_sramWriteSeq;

  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic reqMode = 1'b0;
  logic busy, done, turnaround, chipSelN, writeN, dataOe;
  logic [AW-1:0] sramAddr;
  logic [DW-1:0] sramData;

  always #5 clk = !clk;

  sramWriteSeq #(.CLK_NS(10), .SPEED_GRADE(45), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqData(reqData), .reqMode(reqMode), .busy(busy), .done(done),
    .turnaround(turnaround), .chipSelN(chipSelN), .writeN(writeN),
    .sramAddr(sramAddr), .sramData(sramData), .dataOe(dataOe)
  );

  // Expected timing from the 45 ns limits at 10 ns (R6, R9)
  function automatic int cyc(int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction
  localparam int E_TURN = cyc(15);
  localparam int E_S    = mx(mx(cyc(30), cyc(15) + cyc(15)), cyc(30) - 1);
  localparam int E_R    = mx(1, cyc(45) - 1 - E_S);
  localparam int E_BUSY = 1 + E_S + E_R;

  typedef struct { logic mode; logic [AW-1:0] addr; logic [DW-1:0] data; } item_t;
  item_t expQ[$];

  int checks = 0;
  int fails = 0;
  int pushed = 0;
  int doneSeen = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver
  task automatic doWrite(logic mode, logic [AW-1:0] a, logic [DW-1:0] d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqData = d; reqMode = mode;
    it.mode = mode; it.addr = a; it.data = d;
    expQ.push_back(it);
    pushed++;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = ~a; reqData = ~d;
    chk("R2 busy after accept", int'(busy), 1);
    chk("R2 address presented", int'(sramAddr), int'(a));
  endtask

  // Monitor
  int busyCnt = 0, ceLow = 0, weLow = 0, ceOnly = 0, weOnly = 0;
  int oeCnt = 0, oeOut = 0, turnCnt = 0, moved = 0, idleBad = 0;
  logic [AW-1:0] firstAddr;
  logic [DW-1:0] lastData;
  logic firstCe, firstWe, prevDone = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        if (busyCnt == 0) begin
          firstAddr = sramAddr; firstCe = chipSelN; firstWe = writeN;
        end else if (sramAddr != firstAddr) moved++;
        busyCnt++;
        if (!chipSelN) ceLow++;
        if (!writeN) weLow++;
        if (!chipSelN && writeN) ceOnly++;
        if (chipSelN && !writeN) weOnly++;
        if (turnaround) turnCnt++;
        if (dataOe) begin
          oeCnt++; lastData = sramData;
          if (chipSelN || writeN) oeOut++;
        end
      end else if (!(chipSelN && writeN)) idleBad++;
      if (done && prevDone) chk("R10 done width", 2, 1);
      if (done) begin
        item_t it;
        doneSeen++;
        if (expQ.size() == 0) chk("R3 done with empty queue", 1, 0);
        else begin
          it = expQ.pop_front();
          chk("R9 busy cycles", busyCnt, E_BUSY);
          chk("R8 address moved while busy", moved, 0);
          chk("R2 address", int'(firstAddr), int'(it.addr));
          chk("R2 data at end of write", int'(lastData), int'(it.data));
          chk("R7 dataOe outside strobes", oeOut, 0);
          chk("R11 turnaround cycles", turnCnt, E_TURN);
          if (!it.mode) begin
            chk("R4 first cycle chipSelN", int'(firstCe), 0);
            chk("R4 first cycle writeN", int'(firstWe), 1);
            chk("R4 writeN low cycles", weLow, E_S);
            chk("R4 chipSelN low cycles", ceLow, E_BUSY);
            chk("R4 writeN-only cycles", weOnly, 0);
            chk("R6 chipSelN-only cycles", ceOnly, 1 + E_R);
            chk("R7 dataOe cycles mode0", oeCnt, E_S - E_TURN);
          end else begin
            chk("R5 first cycle writeN", int'(firstWe), 0);
            chk("R5 first cycle chipSelN", int'(firstCe), 1);
            chk("R5 chipSelN low cycles", ceLow, E_S);
            chk("R5 writeN low cycles", weLow, E_BUSY);
            chk("R5 chipSelN-only cycles", ceOnly, 0);
            chk("R6 writeN-only cycles", weOnly, 1 + E_R);
            chk("R7 dataOe cycles mode1", oeCnt, E_S - E_TURN + 1);
          end
        end
        busyCnt = 0; ceLow = 0; weLow = 0; ceOnly = 0; weOnly = 0;
        oeCnt = 0; oeOut = 0; turnCnt = 0; moved = 0;
      end
      prevDone = done;
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 chipSelN", int'(chipSelN), 1);
    chk("R1 writeN", int'(writeN), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 dataOe", int'(dataOe), 0);
    chk("R1 turnaround", int'(turnaround), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doWrite(1'b0, 16'h1234, 8'hA5);
    doWrite(1'b1, 16'hBEEF, 8'h3C);
    doWrite(1'b1, 16'h0001, 8'hFF);
    doWrite(1'b0, 16'hFFFF, 8'h00);

    // R3: request while busy is ignored
    doWrite(1'b0, 16'h4242, 8'h77);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 16'h9999; reqData = 8'h11; reqMode = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R3 address kept after ignored request", int'(sramAddr), 16'h4242);
    chk("R3 done count", doneSeen, pushed);
    chk("R8 idle strobe violations", idleBad, 0);

    doWrite(1'b1, 16'h5A5A, 8'hC3);
    doWrite(1'b0, 16'hA5A5, 8'h3C);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 all writes completed", doneSeen, pushed);
    chk("R10 queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule